// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps calendar time in packed BCD fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year counted from 1970, so the covered span is 1970 to 2069. A 32768 Hz enable input drives a prescaler. The prescaler emits a one-cycle pulse at each second boundary, and the time fields advance by one second on that pulse. The pulse is also an output, so a neighbouring alarm block can use it.

Software sets the time through a simple register write port. Each of the seven fields, plus a leap-year flag kept in the year register, is first written into a staging copy. The running counters take the staged values only after software writes the trigger bit in a separate register that sits right after the seven time registers. The trigger bit clears itself once the load happens, and the load also restarts the prescaler. The leap-year status is not computed by the block: software supplies it as a flag. A control bit selects between 24-hour and 12-hour hour counting. A combinational read port returns the live fields.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After a synchronous active-low reset: seconds, minutes, hours and weekday read 0, day reads 0x01, month reads 0x01, year reads 0x00 with the leap flag clear, control reads 0, the trigger reads 0 and `sec_pulse` is 0.
- R2: `sec_pulse` is high for exactly one cycle after every PRESCALE clock edges at which `tick_32k` is high. A commit clears the prescaler count, so a new second takes a full PRESCALE ticks counted from the commit.
- R3: Seconds and minutes count in BCD from 0x00 to 0x59. Each wraps to 0x00 and carries into the next field.
- R4: When control bit 0 is 1 (24-hour mode), hours count in BCD from 0x00 to 0x23. Hours wrap to 0x00 and carry into both the day and the weekday.
- R5: When control bit 0 is 0 (12-hour mode), hours bits 4:0 hold BCD 01 to 12 and bit 5 is the PM flag. The sequence 11 goes to 12 and toggles PM, and 12 goes to 01 with PM unchanged. Going from 11 PM to 12 AM carries into the day and the weekday.
- R6: The day wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months. In month 0x02 it wraps after 0x29 when the leap flag is set and after 0x28 when it is clear.
- R7: The month wraps from 0x12 to 0x01 and carries into the year. The year wraps from 0x99 to 0x00. The leap flag is never changed by counting.
- R8: The weekday counts 0 to 6 and wraps from 6 to 0 on every day carry.
- R9: The register addresses are: 0 seconds [6:0], 1 minutes [6:0], 2 hours [5:0], 3 weekday [2:0], 4 day [5:0], 5 month [4:0], 6 year [7:0] with the leap flag in [15], 7 trigger [15], 8 control [0]. Writes to 0 through 6 change only the staged copy, and the live fields stay as they are. Reads of 0 through 6 return the live fields zero-extended. Reads of unmapped addresses return 0.
- R10: Writing address 7 with bit 15 set raises the trigger, which reads back as 0x8000 for one cycle. At the next edge every staged field is loaded into the live counters and the trigger clears. Writing address 7 with bit 15 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at the 32768 Hz rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Read data (combinational) |
| sec_pulse | output | 1 | One-cycle pulse at each second boundary |

## Verification
The bench aims at the carry chains where they are deepest.

- **Month ends and February.** It runs the last second of 30-day months, of February with and without the leap flag, and of December in year 99. A design with the wrong last-day table or a lost carry would show a day 31 or a day 29 that should not exist, or a month or year that stays the same.
- **12-hour mode.** It crosses 11:59:59 AM, 11:59:59 PM and 12:59:59. A mishandled PM flag would move the date at noon, or miss the date change at midnight.
- **Staging, trigger and prescaler.** It checks that staged writes stay invisible until the trigger, that the trigger clears itself, and that a commit restarts the prescaler. A design that skipped the prescaler clear would advance the seconds early.

// File: rtl/cal_pkg.sv
// Shared field widths, register addresses, the time record and BCD helpers
// for the calendar counter. Assumes every field value it receives is valid BCD.
package cal_pkg;

    localparam int ADDR_W = 4;
    localparam int REG_W  = 16;

    localparam logic [ADDR_W-1:0] A_SEC    = 4'd0;
    localparam logic [ADDR_W-1:0] A_MIN    = 4'd1;
    localparam logic [ADDR_W-1:0] A_HOUR   = 4'd2;
    localparam logic [ADDR_W-1:0] A_WDAY   = 4'd3;
    localparam logic [ADDR_W-1:0] A_DAY    = 4'd4;
    localparam logic [ADDR_W-1:0] A_MONTH  = 4'd5;
    localparam logic [ADDR_W-1:0] A_YEAR   = 4'd6;
    localparam logic [ADDR_W-1:0] A_COMMIT = 4'd7;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd8;

    localparam int FLAG_BIT = 15;

    typedef struct packed {
        logic       leap;
        logic [7:0] year;
        logic [4:0] month;
        logic [5:0] day;
        logic [2:0] wday;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } cal_time_t;

    localparam cal_time_t RESET_TIME = '{leap: 1'b0, year: 8'h00, month: 5'h01,
                                         day: 6'h01, wday: 3'd0, hour: 6'h00,
                                         min: 7'h00, sec: 7'h00};

    // Adds one to a two-digit BCD value (no wrap at 99).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Gives the last day, in BCD, of a BCD month, using the software leap flag.
    function automatic logic [5:0] month_last_day(input logic [4:0] m, input logic leap);
        case (m)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
// One-second prescaler. It counts PRESCALE enabled ticks and raises a
// registered one-cycle pulse on the last one. Assumes PRESCALE >= 2.
// A clear input restarts the count.
module cal_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    output logic pulse
);
    localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

    logic [CNT_W-1:0] cnt;

    // Counts the ticks, restarts on clear, and flags the last tick of each second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (clear) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == LAST) begin
                    cnt   <= '0;
                    pulse <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cal_regfile.sv
// Register file. It holds the staged time fields, the control bit and the
// self-clearing commit trigger, and it muxes the live fields onto the read
// port. Writes never touch the live time directly.
module cal_regfile
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  cal_time_t         live,
    output cal_time_t         staged,
    output logic              mode24,
    output logic              commit,
    output logic [REG_W-1:0]  rd_data
);
    // Captures the staged fields and the control bit, and pulses the trigger for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= RESET_TIME;
            mode24 <= 1'b0;
            commit <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    A_SEC:    staged.sec   <= wr_data[6:0];
                    A_MIN:    staged.min   <= wr_data[6:0];
                    A_HOUR:   staged.hour  <= wr_data[5:0];
                    A_WDAY:   staged.wday  <= wr_data[2:0];
                    A_DAY:    staged.day   <= wr_data[5:0];
                    A_MONTH:  staged.month <= wr_data[4:0];
                    A_YEAR: begin
                        staged.year <= wr_data[7:0];
                        staged.leap <= wr_data[FLAG_BIT];
                    end
                    A_COMMIT: commit <= wr_data[FLAG_BIT] && !commit;
                    A_CTRL:   mode24 <= wr_data[0];
                    default:  ;
                endcase
            end
        end
    end

    // Selects the live field, trigger or control bit for the read port.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_SEC:    rd_data[6:0] = live.sec;
            A_MIN:    rd_data[6:0] = live.min;
            A_HOUR:   rd_data[5:0] = live.hour;
            A_WDAY:   rd_data[2:0] = live.wday;
            A_DAY:    rd_data[5:0] = live.day;
            A_MONTH:  rd_data[4:0] = live.month;
            A_YEAR: begin
                rd_data[7:0]     = live.year;
                rd_data[FLAG_BIT] = live.leap;
            end
            A_COMMIT: rd_data[FLAG_BIT] = commit;
            A_CTRL:   rd_data[0] = mode24;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cal_time_core.sv
// Live time counters. On a load the whole staged record is copied in. On an
// advance pulse the record moves one second forward, with BCD carries through
// the hours (24- or 12-hour), the day (using the month and the leap flag),
// the weekday, the month and the year. Load has priority over advance.
module cal_time_core
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      load,
    input  logic      mode24,
    input  cal_time_t staged,
    output cal_time_t cur
);
    cal_time_t  nxt;
    logic       c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0] sec_inc, min_inc, hr24_inc, hr12_inc, day_inc, mon_inc, yr_inc;
    logic [5:0] last_day;
    logic       pm;

    assign sec_inc  = bcd_inc({1'b0, cur.sec});
    assign min_inc  = bcd_inc({1'b0, cur.min});
    assign hr24_inc = bcd_inc({2'b0, cur.hour});
    assign hr12_inc = bcd_inc({3'b0, cur.hour[4:0]});
    assign day_inc  = bcd_inc({2'b0, cur.day});
    assign mon_inc  = bcd_inc({3'b0, cur.month});
    assign yr_inc   = bcd_inc(cur.year);
    assign last_day = month_last_day(cur.month, cur.leap);
    assign pm       = cur.hour[5];

    // Works out the record one second later, carrying field by field.
    always_comb begin
        nxt    = cur;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;

        if (cur.sec >= 7'h59) begin
            nxt.sec = 7'h00;
            c_min   = 1'b1;
        end else begin
            nxt.sec = sec_inc[6:0];
        end

        if (c_min) begin
            if (cur.min >= 7'h59) begin
                nxt.min = 7'h00;
                c_hour  = 1'b1;
            end else begin
                nxt.min = min_inc[6:0];
            end
        end

        if (c_hour) begin
            if (mode24) begin
                if (cur.hour >= 6'h23) begin
                    nxt.hour = 6'h00;
                    c_day    = 1'b1;
                end else begin
                    nxt.hour = hr24_inc[5:0];
                end
            end else if (cur.hour[4:0] == 5'h11) begin
                nxt.hour = {~pm, 5'h12};
                c_day    = pm;
            end else if (cur.hour[4:0] >= 5'h12) begin
                nxt.hour = {pm, 5'h01};
            end else begin
                nxt.hour = {pm, hr12_inc[4:0]};
            end
        end

        if (c_day) begin
            nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
            if (cur.day >= last_day) begin
                nxt.day = 6'h01;
                c_mon   = 1'b1;
            end else begin
                nxt.day = day_inc[5:0];
            end
        end

        if (c_mon) begin
            if (cur.month >= 5'h12) begin
                nxt.month = 5'h01;
                c_year    = 1'b1;
            end else begin
                nxt.month = mon_inc[4:0];
            end
        end

        if (c_year) begin
            nxt.year = (cur.year >= 8'h99) ? 8'h00 : yr_inc;
        end
    end

    // Holds the live record: reset, load from staging, or advance one second.
    always_ff @(posedge clk) begin
        if (!rst_n)    cur <= RESET_TIME;
        else if (load) cur <= staged;
        else if (adv)  cur <= nxt;
    end
endmodule

// File: rtl/bcd_calendar_counter.sv
// Top of the BCD calendar counter. It ties together the prescaler, the
// register file and the live time core. Assumes tick_32k is a one-cycle
// enable that arrives at the oscillator rate.
module bcd_calendar_counter
    import cal_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              sec_pulse
);
    cal_time_t staged_q;
    cal_time_t live_q;
    logic      commit;
    logic      mode24;

    cal_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_32k),
        .clear (commit),
        .pulse (sec_pulse)
    );

    cal_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .live    (live_q),
        .staged  (staged_q),
        .mode24  (mode24),
        .commit  (commit),
        .rd_data (rd_data)
    );

    cal_time_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (sec_pulse),
        .load   (commit),
        .mode24 (mode24),
        .staged (staged_q),
        .cur    (live_q)
    );
endmodule

// File: rtl/cal_counter_chk.sv
// Property checker for the calendar counter, attached to the top by bind.
module cal_counter_chk
    import cal_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick_32k,
    input logic      sec_pulse,
    input logic      commit,
    input cal_time_t staged,
    input cal_time_t live
);
    assert_pulse_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> !sec_pulse);

    assert_pulse_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> $past(tick_32k));

    assert_trigger_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_commit_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (live == $past(staged)));

    assert_live_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_pulse && !commit) |=> $stable(live));

    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !commit && live.sec == 7'h59) |=> (live.sec == 7'h00));
endmodule

bind bcd_calendar_counter cal_counter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_32k  (tick_32k),
    .sec_pulse (sec_pulse),
    .commit    (commit),
    .staged    (staged_q),
    .live      (live_q)
);

// File: tb/bcd_calendar_counter_tb.sv
module bcd_calendar_counter_tb;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_32k = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        sec_pulse;

    int nchk = 0;
    int nfail = 0;

    // bench model of the time, in binary
    int t_s, t_m, t_h, t_wd, t_d, t_mo, t_y, t_leap, t_m24;

    always #10 clk = ~clk;

    bcd_calendar_counter #(.PRESCALE(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .sec_pulse(sec_pulse)
    );

    function automatic int to_bcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int days_in(int mo, int leap);
        if (mo == 2) return leap ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int enc_hour(int h, int m24);
        int h12;
        if (m24 != 0) return to_bcd(h);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return to_bcd(h12) | ((h >= 12) ? 32 : 0);
    endfunction

    task automatic check(string tag, int got, int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(int a, output int v);
        rd_addr = a[3:0];
        #1;
        v = int'(rd_data);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a[3:0];
        wr_data = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic model_step();
        t_s++;
        if (t_s < 60) return;
        t_s = 0; t_m++;
        if (t_m < 60) return;
        t_m = 0; t_h++;
        if (t_h < 24) return;
        t_h = 0;
        t_wd = (t_wd + 1) % 7;
        t_d++;
        if (t_d <= days_in(t_mo, t_leap)) return;
        t_d = 1; t_mo++;
        if (t_mo <= 12) return;
        t_mo = 1;
        t_y = (t_y + 1) % 100;
    endtask

    task automatic check_all(string tag);
        int v;
        rd(0, v); check({tag, " sec"}, v, to_bcd(t_s));
        rd(1, v); check({tag, " min"}, v, to_bcd(t_m));
        rd(2, v); check({tag, " hour"}, v, enc_hour(t_h, t_m24));
        rd(3, v); check({tag, " wday"}, v, t_wd);
        rd(4, v); check({tag, " day"}, v, to_bcd(t_d));
        rd(5, v); check({tag, " month"}, v, to_bcd(t_mo));
        rd(6, v); check({tag, " year"}, v, to_bcd(t_y) | (t_leap << 15));
    endtask

    // stages every field and control from the model, then commits
    task automatic set_time();
        wr(8, t_m24);
        wr(0, to_bcd(t_s));
        wr(1, to_bcd(t_m));
        wr(2, enc_hour(t_h, t_m24));
        wr(3, t_wd);
        wr(4, to_bcd(t_d));
        wr(5, to_bcd(t_mo));
        wr(6, to_bcd(t_y) | (t_leap << 15));
        wr(7, 16'h8000);
        @(negedge clk);
    endtask

    task automatic ticks(int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pulses += int'(sec_pulse);
            tick_32k = 1'b1;
        end
        @(negedge clk);
        pulses += int'(sec_pulse);
        tick_32k = 1'b0;
        @(negedge clk);
        pulses += int'(sec_pulse);
    endtask

    task automatic one_second(string tag);
        int np;
        ticks(P, np);
        check({tag, " R2 pulse count"}, np, 1);
        model_step();
        check_all(tag);
    endtask

    task automatic load(int s, int m, int h, int wd, int d, int mo, int y, int lp, int m24);
        t_s = s; t_m = m; t_h = h; t_wd = wd; t_d = d; t_mo = mo; t_y = y;
        t_leap = lp; t_m24 = m24;
        set_time();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        int v, np, seed;
        seed = $urandom(1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        t_s = 0; t_m = 0; t_h = 0; t_wd = 0; t_d = 1; t_mo = 1; t_y = 0; t_leap = 0; t_m24 = 1;
        rd(0, v); check("R1 sec", v, 0);
        rd(2, v); check("R1 hour", v, 0);
        rd(4, v); check("R1 day", v, 1);
        rd(5, v); check("R1 month", v, 1);
        rd(6, v); check("R1 year", v, 0);
        rd(7, v); check("R1 trigger", v, 0);
        rd(8, v); check("R1 control", v, 0);
        check("R1 pulse", int'(sec_pulse), 0);

        // R9 staging does not reach live without a trigger; unmapped read 0
        wr(0, 16'h0042);
        wr(4, 16'h0015);
        rd(0, v); check("R9 staged sec not live", v, 0);
        rd(4, v); check("R9 staged day not live", v, 1);
        rd(12, v); check("R9 unmapped read", v, 0);

        // R10 write of address 7 without bit 15 has no effect
        wr(7, 16'h7fff);
        rd(7, v); check("R10 no trigger", v, 0);
        rd(0, v); check("R10 no load", v, 0);

        // R10 trigger readback and self-clear
        wr(7, 16'h8000);
        rd(7, v); check("R10 trigger set", v, 16'h8000);
        @(negedge clk);
        rd(7, v); check("R10 trigger cleared", v, 0);
        rd(0, v); check("R10 sec loaded", v, 16'h42);
        rd(4, v); check("R10 day loaded", v, 16'h15);

        // R4 control readback and 24-hour day carry, R8 weekday wrap 6->0
        load(59, 59, 23, 6, 14, 5, 30, 0, 1);
        rd(8, v); check("R4 control", v, 1);
        one_second("R4 R8 midnight");

        // R3 minute carry
        load(59, 58, 10, 2, 3, 3, 5, 0, 1);
        one_second("R3 minute carry");

        // R6 month ends
        load(59, 59, 23, 1, 28, 2, 23, 0, 1);
        one_second("R6 feb nonleap");
        load(59, 59, 23, 1, 28, 2, 24, 1, 1);
        one_second("R6 feb leap 28");
        load(59, 59, 23, 2, 29, 2, 24, 1, 1);
        one_second("R6 feb leap 29");
        load(59, 59, 23, 3, 30, 4, 10, 0, 1);
        one_second("R6 april");
        load(59, 59, 23, 3, 30, 11, 10, 0, 1);
        one_second("R6 november");
        load(59, 59, 23, 3, 30, 7, 10, 0, 1);
        one_second("R6 july 30");

        // R7 year wrap with leap flag kept
        load(59, 59, 23, 4, 31, 12, 99, 1, 1);
        one_second("R7 year wrap");
        load(59, 59, 23, 4, 31, 12, 41, 0, 1);
        one_second("R7 new year");

        // R5 12-hour mode
        load(59, 59, 11, 0, 10, 6, 50, 0, 0);
        rd(8, v); check("R5 control", v, 0);
        one_second("R5 noon");
        load(59, 59, 23, 0, 30, 6, 50, 0, 0);
        one_second("R5 midnight");
        load(59, 59, 12, 0, 10, 6, 50, 0, 0);
        one_second("R5 twelve to one");
        load(59, 59, 0, 0, 10, 6, 50, 0, 0);
        one_second("R5 twelve am to one");

        // R2 commit clears the prescaler
        load(10, 0, 5, 1, 1, 1, 0, 0, 1);
        ticks(P - 1, np);
        check("R2 no early pulse", np, 0);
        wr(7, 16'h8000);
        @(negedge clk);
        ticks(P - 1, np);
        check("R2 count restarted", np, 0);
        rd(0, v); check("R2 sec held", v, to_bcd(10));
        ticks(1, np);
        check("R2 pulse after full count", np, 1);
        model_step();
        check_all("R2 advance");

        // random mix
        for (int it = 0; it < 40; it++) begin
            int near, nstep;
            near = $urandom % 2;
            t_m24 = $urandom % 2;
            t_leap = $urandom % 2;
            t_y = $urandom % 100;
            t_mo = 1 + $urandom % 12;
            t_d = 1 + $urandom % days_in(t_mo, t_leap);
            t_wd = $urandom % 7;
            t_h = near ? 23 : $urandom % 24;
            t_m = near ? 59 : $urandom % 60;
            t_s = near ? 57 + $urandom % 3 : $urandom % 60;
            if (near != 0 && ($urandom % 2) != 0) t_d = days_in(t_mo, t_leap);
            set_time();
            check_all("R9 R10 random load");
            nstep = 1 + $urandom % 3;
            for (int k = 0; k < nstep; k++) one_second("R3 R6 R7 R8 random step");
        end

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule